// File: doc/BRIEF.md
# Coalescing Write Buffer

A small, fully associative store buffer sits between a processor and the coherence network. Stores to the same block are gathered into one entry. Only one block write-back then goes out for a burst of stores, not one global transaction per store. Entries are allocated only by stores. Lookups from the read path never create an entry. Each word of an entry carries one bit that marks it both valid and dirty. An entry is valid when any of its word bits is set.

Buffered blocks leave the buffer in two cases only:
- **Eviction:** a store to a new block finds every entry occupied. The entry written least recently is sent out first.
- **Synchronization:** the processor raises a synchronization request. The buffer then empties completely, one transaction per handshake, and reports completion. The request must stay high until completion is reported.

Every outgoing transaction carries the block address, the whole block's data and the per-word dirty mask. Only the words marked in the mask carry meaning.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset the buffer is empty: `wb_valid_o` is 0, `sync_done_o` is 0, `rd_hit_o` is 0, and `wr_ready_o` is 1 while `sync_req_i` is low.
- R2: A store to a block that is not held is accepted in the cycle it is presented, provided a free entry exists and `sync_req_i` is low. It allocates the lowest-numbered free entry and produces no write-back transaction.
- R3: Stores to a block already held merge into that entry, and a later store to the same word overwrites the earlier data. At most one entry ever holds a given block.
- R4: The word index is `wr_addr_i[1:0]` and the block address is `wr_addr_i[ADDR_W-1:2]`. In a transaction, bit k of `wb_mask_o` is set exactly for the words stored since the entry was allocated. Word k's data sits in `wb_data_o[32k+31:32k]`.
- R5: Suppose a store misses and all four entries are occupied:
  - `wr_ready_o` is 0 in that cycle.
  - In the next cycle `wb_valid_o` presents the least recently written entry.
  - In the cycle after the handshake, the store is accepted into the freed entry.
- R6: While `sync_req_i` is high, every held entry is emitted exactly once, lowest-numbered entry first, one per `wb_valid_o`/`wb_ready_i` handshake.
- R7: `sync_done_o` is 1 exactly when `sync_req_i` is high and the buffer is empty. `wr_ready_o` is 0 whenever `sync_req_i` is high.
- R8: `rd_hit_o` is 1 only when the looked-up block is held and its word is dirty, and `rd_data_o` then returns the buffered word. A read never allocates an entry.
- R9: While `wb_valid_o` is 1 and `wb_ready_i` is 0, `wb_valid_o`, `wb_addr_o` and `wb_mask_o` stay unchanged. `wr_ready_o` is 0 in every cycle in which `wb_valid_o` is 1.
- R10: Every emitted transaction has a non-zero `wb_mask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Store request |
| wr_ready_o | output | 1 | Store accepted this cycle when high with `wr_valid_i` |
| wr_addr_i | input | ADDR_W | Word address of the store |
| wr_data_i | input | WORD_W | Store data |
| rd_addr_i | input | ADDR_W | Word address looked up by the read path |
| rd_hit_o | output | 1 | Looked-up word is held dirty in the buffer |
| rd_data_o | output | WORD_W | Buffered word on a hit, zero otherwise |
| sync_req_i | input | 1 | Synchronization request, held until `sync_done_o` |
| sync_done_o | output | 1 | Buffer drained for the pending synchronization |
| wb_valid_o | output | 1 | Write-back transaction valid |
| wb_ready_i | input | 1 | Network accepts the transaction |
| wb_addr_o | output | ADDR_W-2 | Block address of the transaction |
| wb_data_o | output | 4*WORD_W | Whole block data |
| wb_mask_o | output | 4 | Per-word dirty mask |

## Verification
Assertions check these properties on every cycle:
- at most one entry matches any block;
- the recency ranks stay a permutation;
- a pending transaction holds steady under backpressure and never carries an empty mask;
- stores stall whenever a transaction is offered;
- an accepted store never triggers an immediate write-back;
- completion never coincides with an outstanding transaction.

Only the bench's scenarios can show the remaining behaviour, because it depends on the store history:
- which block is chosen as victim;
- that merged and overwritten words produce the right data and mask;
- that the drain order is correct;
- that read lookups leave the contents untouched.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  parameter int unsigned DEF_ENTRIES = 4;
  parameter int unsigned DEF_WORDS   = 4;
  parameter int unsigned DEF_WORD_W  = 32;
  parameter int unsigned DEF_ADDR_W  = 30;
endpackage

// File: rtl/wcb_lookup.sv
module wcb_lookup #(
  parameter int unsigned N     = 4,
  parameter int unsigned TAG_W = 28,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              valid_i,
  input  logic [N-1:0][TAG_W-1:0]   tags_i,
  input  logic [TAG_W-1:0]          key_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          hit_idx_o
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid_i[i] && (tags_i[i] == key_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) hit_idx_o = IDX_W'(i);
  end
  assign hit_o = |match;

  // R3
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/wcb_lrw.sv
module wcb_lrw #(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  // rank 0 = most recently written, N-1 = least recently written
  logic [N-1:0][IDX_W-1:0] rank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (upd_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == upd_idx_i)             rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[upd_idx_i]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++)
      if (rank_q[i] == IDX_W'(N - 1)) victim_o = IDX_W'(i);
  end

  for (genvar i = 0; i < N; i++) begin : g_pi
    for (genvar j = i + 1; j < N; j++) begin : g_pj
      // R5
      rank_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rank_q[i] != rank_q[j]);
    end
  end
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf #(
  parameter int unsigned N_ENTRIES = wcb_pkg::DEF_ENTRIES,
  parameter int unsigned WORDS     = wcb_pkg::DEF_WORDS,
  parameter int unsigned WORD_W    = wcb_pkg::DEF_WORD_W,
  parameter int unsigned ADDR_W    = wcb_pkg::DEF_ADDR_W,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES),
  localparam int unsigned OFF_W = $clog2(WORDS),
  localparam int unsigned TAG_W = ADDR_W - OFF_W,
  localparam int unsigned BLK_W = WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_hit_o,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              sync_req_i,
  output logic              sync_done_o,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [TAG_W-1:0]  wb_addr_o,
  output logic [BLK_W-1:0]  wb_data_o,
  output logic [WORDS-1:0]  wb_mask_o
);
  logic [N_ENTRIES-1:0][TAG_W-1:0]              tag_q;
  logic [N_ENTRIES-1:0][WORDS-1:0][WORD_W-1:0]  dat_q;
  logic [N_ENTRIES-1:0][WORDS-1:0]              dirty_q;
  logic [N_ENTRIES-1:0]                         vld;
  logic                                         evict_q;

  logic             wr_hit, rd_hit, any_free, any_vld, wr_fire, wb_fire;
  logic [IDX_W-1:0] wr_hit_idx, rd_idx, free_idx, drain_idx, victim, wb_sel, tgt;
  logic [TAG_W-1:0] wr_tag, rd_tag;
  logic [OFF_W-1:0] wr_off, rd_off;

  assign wr_tag = wr_addr_i[ADDR_W-1:OFF_W];
  assign wr_off = wr_addr_i[OFF_W-1:0];
  assign rd_tag = rd_addr_i[ADDR_W-1:OFF_W];
  assign rd_off = rd_addr_i[OFF_W-1:0];

  // combined valid/dirty: entry is live while any word is dirty
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_vld
    assign vld[i] = |dirty_q[i];
  end

  always_comb begin
    free_idx  = '0;
    drain_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx  = IDX_W'(i);
      if (vld[i])  drain_idx = IDX_W'(i);
    end
  end
  assign any_free = ~&vld;
  assign any_vld  = |vld;

  wcb_lookup #(.N(N_ENTRIES), .TAG_W(TAG_W)) u_wr_lookup (
    .clk_i, .rst_ni, .valid_i(vld), .tags_i(tag_q), .key_i(wr_tag),
    .hit_o(wr_hit), .hit_idx_o(wr_hit_idx)
  );

  wcb_lookup #(.N(N_ENTRIES), .TAG_W(TAG_W)) u_rd_lookup (
    .clk_i, .rst_ni, .valid_i(vld), .tags_i(tag_q), .key_i(rd_tag),
    .hit_o(rd_hit), .hit_idx_o(rd_idx)
  );

  assign tgt = wr_hit ? wr_hit_idx : free_idx;

  wcb_lrw #(.N(N_ENTRIES)) u_lrw (
    .clk_i, .rst_ni, .upd_i(wr_fire), .upd_idx_i(tgt), .victim_o(victim)
  );

  assign wr_ready_o  = !sync_req_i && !evict_q && (wr_hit || any_free);
  assign wr_fire     = wr_valid_i && wr_ready_o;
  assign wb_valid_o  = evict_q || (sync_req_i && any_vld);
  assign wb_fire     = wb_valid_o && wb_ready_i;
  assign wb_sel      = evict_q ? victim : drain_idx;
  assign wb_addr_o   = tag_q[wb_sel];
  assign wb_data_o   = dat_q[wb_sel];
  assign wb_mask_o   = dirty_q[wb_sel];
  assign sync_done_o = sync_req_i && !any_vld && !evict_q;

  assign rd_hit_o  = rd_hit && dirty_q[rd_idx][rd_off];
  assign rd_data_o = rd_hit_o ? dat_q[rd_idx][rd_off] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evict_q <= 1'b0;
    end else if (wb_fire) begin
      evict_q <= 1'b0;
    end else if (wr_valid_i && !sync_req_i && !evict_q && !wr_hit && !any_free) begin
      evict_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      dat_q   <= '0;
      dirty_q <= '0;
    end else begin
      // stores and write-backs never overlap: wr_ready_o is low while wb_valid_o
      if (wb_fire) dirty_q[wb_sel] <= '0;
      if (wr_fire) begin
        tag_q[tgt]           <= wr_tag;
        dat_q[tgt][wr_off]   <= wr_data_i;
        dirty_q[tgt][wr_off] <= 1'b1;
      end
    end
  end

  // R9
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_addr_o) && $stable(wb_mask_o));
  // R9
  wb_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> !wr_ready_o);
  // R10
  wb_mask_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_mask_o != '0));
  // R2
  no_eager_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_ready_o |=> !wb_valid_o || sync_req_i);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_done_o |-> !wb_valid_o && !wr_ready_o);
endmodule

// File: tb/coalesce_wbuf_tb_top.sv
module coalesce_wbuf_tb_top;
  localparam int NE = 4;
  localparam int AW = 30;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 1'b0, wr_ready_o;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic rd_hit_o, sync_req_i = 1'b0, sync_done_o;
  logic wb_valid_o, wb_ready_i = 1'b1;
  logic [AW-3:0] wb_addr_o;
  logic [127:0] wb_data_o;
  logic [3:0] wb_mask_o;

  always #5 clk = ~clk;

  coalesce_wbuf dut_i (
    .clk_i(clk), .rst_ni, .wr_valid_i, .wr_ready_o, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_hit_o, .rd_data_o, .sync_req_i, .sync_done_o,
    .wb_valid_o, .wb_ready_i, .wb_addr_o, .wb_data_o, .wb_mask_o
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [AW-3:0] m_tag [NE];
  logic [31:0]   m_dat [NE][4];
  logic [3:0]    m_mask[NE];
  int            m_rank[NE];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(input logic [AW-3:0] t);
    for (int i = 0; i < NE; i++) if (m_mask[i] != 0 && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < NE; i++) if (m_mask[i] == 0) return i;
    return -1;
  endfunction

  function automatic int m_oldest();
    for (int i = 0; i < NE; i++) if (m_rank[i] == NE - 1) return i;
    return 0;
  endfunction

  function automatic logic [127:0] exp_blk(input int s);
    logic [127:0] b = '0;
    for (int k = 0; k < 4; k++) if (m_mask[s][k]) b[32*k +: 32] = m_dat[s][k];
    return b;
  endfunction

  function automatic logic [127:0] masked(input logic [127:0] d, input logic [3:0] m);
    logic [127:0] b = '0;
    for (int k = 0; k < 4; k++) if (m[k]) b[32*k +: 32] = d[32*k +: 32];
    return b;
  endfunction

  task automatic check_wb(input int s, input string req);
    chk(wb_valid_o === 1'b1, req, wb_valid_o, 1);
    chk(wb_addr_o === m_tag[s], req, wb_addr_o, m_tag[s]);
    chk(wb_mask_o === m_mask[s], req, wb_mask_o, m_mask[s]);
    chk(masked(wb_data_o, wb_mask_o) === exp_blk(s), req, masked(wb_data_o, wb_mask_o), exp_blk(s));
  endtask

  // starts and ends shortly after a falling edge
  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    int h, s, w;
    h = m_find(a[AW-1:2]);
    w = int'(a[1:0]);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    #1;
    if (h < 0 && m_free() < 0) begin
      chk(wr_ready_o === 1'b0, "R5 stall on full miss", wr_ready_o, 0);
      @(negedge clk); #1;
      s = m_oldest();
      check_wb(s, "R5 victim");
      @(negedge clk); #1;
      m_mask[s] = 4'b0;
    end
    chk(wr_ready_o === 1'b1, "R2 accept", wr_ready_o, 1);
    @(negedge clk);
    s = (h >= 0) ? h : m_free();
    m_tag[s] = a[AW-1:2];
    m_dat[s][w] = d;
    m_mask[s][w] = 1'b1;
    for (int i = 0; i < NE; i++) if (i != s && m_rank[i] < m_rank[s]) m_rank[i]++;
    m_rank[s] = 0;
    wr_valid_i = 1'b0;
    #1;
    chk(wb_valid_o === 1'b0, "R2 no write-back after store", wb_valid_o, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int h;
    bit eh;
    logic [31:0] ed;
    h = m_find(a[AW-1:2]);
    eh = (h >= 0) && m_mask[h][a[1:0]];
    ed = eh ? m_dat[h][a[1:0]] : 32'h0;
    rd_addr_i = a;
    #1;
    chk(rd_hit_o === eh, "R8 read hit", rd_hit_o, eh);
    if (eh) chk(rd_data_o === ed, "R8 read data", rd_data_o, ed);
  endtask

  task automatic do_sync(input bit stall);
    int s;
    logic [AW-3:0] held;
    sync_req_i = 1'b1;
    #1;
    chk(wr_ready_o === 1'b0, "R7 stores blocked in sync", wr_ready_o, 0);
    while (m_free() >= 0 ? (m_find_any()) : 1) begin
      s = m_lowest();
      check_wb(s, "R6 drain order");
      chk(sync_done_o === 1'b0, "R7 not done early", sync_done_o, 0);
      if (stall) begin
        held = wb_addr_o;
        wb_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(wb_valid_o === 1'b1 && wb_addr_o === held, "R9 hold under backpressure", wb_addr_o, held);
        chk(wr_ready_o === 1'b0, "R9 stall while offered", wr_ready_o, 0);
        wb_ready_i = 1'b1;
        stall = 0;
      end
      @(negedge clk); #1;
      m_mask[s] = 4'b0;
    end
    chk(sync_done_o === 1'b1, "R7 done when empty", sync_done_o, 1);
    chk(wb_valid_o === 1'b0, "R6 nothing left", wb_valid_o, 0);
    sync_req_i = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit m_find_any();
    for (int i = 0; i < NE; i++) if (m_mask[i] != 0) return 1;
    return 0;
  endfunction

  function automatic int m_lowest();
    for (int i = 0; i < NE; i++) if (m_mask[i] != 0) return i;
    return 0;
  endfunction

  function automatic logic [AW-1:0] mk(input int blk, input int w);
    return {28'(blk), 2'(w)};
  endfunction

  initial begin
    for (int i = 0; i < NE; i++) begin m_mask[i] = 0; m_rank[i] = i; m_tag[i] = '0; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(wr_ready_o === 1'b1, "R1 ready after reset", wr_ready_o, 1);
    chk(wb_valid_o === 1'b0, "R1 no output after reset", wb_valid_o, 0);
    chk(sync_done_o === 1'b0, "R1 done low after reset", sync_done_o, 0);
    chk(rd_hit_o === 1'b0, "R1 no read hit after reset", rd_hit_o, 0);

    // R3 R4: merge and overwrite within one block
    do_write(mk(7, 0), 32'h1111_0000);
    do_write(mk(7, 2), 32'h2222_0002);
    do_write(mk(7, 0), 32'h3333_0000);
    do_read(mk(7, 0));
    do_read(mk(7, 1));
    do_read(mk(7, 2));
    do_sync(0);

    // R8: read misses allocate nothing, so sync finishes at once
    for (int i = 0; i < 6; i++) do_read(mk(20 + i, i % 4));
    do_sync(0);

    // R5: fill, touch block 1 again, then a fifth block evicts block 2
    do_write(mk(1, 0), 32'hA0);
    do_write(mk(2, 1), 32'hA1);
    do_write(mk(3, 2), 32'hA2);
    do_write(mk(4, 3), 32'hA3);
    do_write(mk(1, 3), 32'hA4);
    do_write(mk(5, 0), 32'hA5);
    do_write(mk(6, 1), 32'hA6);
    // R9: drain with backpressure
    do_sync(1);

    // random mix
    for (int n = 0; n < 500; n++) begin
      int op, blk, w;
      op = int'($urandom % 10);
      blk = int'($urandom % 6);
      w = int'($urandom % 4);
      if (op < 7)      do_write(mk(blk, w), $urandom);
      else if (op < 9) do_read(mk(blk, w));
      else             do_sync(($urandom % 4) == 0);
    end
    do_sync(0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule